// File: doc/BRIEF.md
# Multiword Carry-Chained Integer Adder

This block is a 64-bit integer add unit meant to sit in an execution pipeline. It lets software build additions of any width as a chain of word operations. Each operation is taken on a valid strobe and its result appears one clock later.

Carries can pass between words in two ways. In the first, the carry travels through a general register. A plain add sums two operands and a third addend. A companion generate-carry operation computes the same three-input sum but returns only its carry count, zero-extended to a full word. In the second, the carry lives in one internal status flag. An add-with-carry operation uses the flag as its carry-in and writes its carry-out back into the flag. A clear operation zeroes the flag before the lowest word of a chain.

A pair mode works 128 bits at a time. It treats a low/high operand pair as one value and uses the same flag as carry-in and carry-out. The datapath itself stays one word wide. No extra carry or overflow bits are held beside the result.

Top module: `mwadd_unit`

## Requirements
- R1: Opcode 0 (plain add) returns (a + b + c) modulo 2^64 in the low result word.
- R2: Opcode 0 and opcode 1 leave the status flag unchanged.
- R3: Opcode 1 (generate carry) returns floor((a + b + c) / 2^64), zero-extended to 64 bits. This value is 0, 1 or 2, and it reaches 2 when all three inputs are all ones.
- R4: Opcode 2 (add with carry) returns (a + b + flag) modulo 2^64 and loads the flag with the carry-out of that sum.
- R5: Opcode 3 (clear flag) sets the flag to 0 and returns a zero result.
- R6: Opcode 2 ignores the third addend input c.
- R7: Opcode 4 (pair add with carry) returns {a_hi,a} + {b_hi,b} + flag modulo 2^128 across the high and low result words, and loads the flag with the 128-bit carry-out. For every other opcode the high result word is zero.
- R8: A strobed operation shows its result and a high valid output on the clock edge after the strobe. A cycle without a strobe drives valid low and holds the result and the flag.
- R9: Opcodes 5, 6 and 7 return a zero result and leave the flag unchanged.
- R10: Synchronous reset clears the valid output, both result words and the flag.
- R11: Back-to-back flag-chained operations each see the flag written by the previous one. A clear followed by four add-with-carry operations, issued low word first, yields a 256-bit sum with bit 256 in the flag. The same holds for the register-carry chain of plain add and generate carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode (0 add, 1 generate carry, 2 add with carry, 3 clear flag, 4 pair add with carry) |
| a_i | input | 64 | First operand, low word |
| b_i | input | 64 | Second operand, low word |
| c_i | input | 64 | Third addend for opcodes 0 and 1 |
| a_hi_i | input | 64 | First operand, high word (pair mode) |
| b_hi_i | input | 64 | Second operand, high word (pair mode) |
| valid_o | output | 1 | Result valid, one clock after the strobe |
| res_o | output | 64 | Result, low word |
| res_hi_o | output | 64 | Result, high word (pair mode, else zero) |
| flag_o | output | 1 | Current status flag |

## Verification
The bench aims at a few specific corner cases.

- All-ones operands with an all-ones third addend push the carry count to 2. A generate-carry path that kept only one carry bit would report 1.
- An all-ones chain plus one ripples a carry through every word into bit 256. A design that lost the flag between back-to-back operations, or that read the third addend in flag mode, would give wrong upper words.
- The flag is set first, then plain adds, generate carries and unused opcodes are issued. This exposes any path that disturbs the flag when it should not.
- Idle cycles check that nothing moves without a strobe.
- Random 256-bit sums are checked through the register chain, the flag chain and the pair mode against a wide reference sum.

// File: rtl/mwadd_pkg.sv
package mwadd_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_GENC = 3'd1,
    OP_ADC  = 3'd2,
    OP_CLRF = 3'd3,
    OP_ADC2 = 3'd4
  } op_e;
endpackage

// File: rtl/mwadd_adder3.sv
// Three-input word adder: modular sum plus the full carry count (0..2).
module mwadd_adder3 #(
  parameter int W = 64
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [1:0]   cnt
);
  logic [W+1:0] full;

  assign full = {2'b00, x} + {2'b00, y} + {2'b00, z};
  assign sum  = full[W-1:0];
  assign cnt  = full[W+1:W];
endmodule

// File: rtl/mwadd_flag.sv
// Single status flag with synchronous reset and write enable.
module mwadd_flag (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/mwadd_unit.sv
module mwadd_unit #(
  parameter int W = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        valid_i,
  input  logic [mwadd_pkg::OP_W-1:0]  op_i,
  input  logic [W-1:0]                a_i,
  input  logic [W-1:0]                b_i,
  input  logic [W-1:0]                c_i,
  input  logic [W-1:0]                a_hi_i,
  input  logic [W-1:0]                b_hi_i,
  output logic                        valid_o,
  output logic [W-1:0]                res_o,
  output logic [W-1:0]                res_hi_o,
  output logic                        flag_o
);
  import mwadd_pkg::*;

  localparam int LANES = 2;

  op_e          op;
  logic         flag_q;
  logic         flag_we;
  logic         flag_d;
  logic         use_flag;
  logic [W-1:0] res_lo_d;
  logic [W-1:0] res_hi_d;

  assign op       = op_e'(op_i);
  assign use_flag = (op == OP_ADC) || (op == OP_ADC2);

  // Lane 0 takes the low words; each later lane takes the next pair
  // and the carry of the lane below it.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [W-1:0] xin, yin, zin, sum;
    logic [1:0]   cnt;

    if (k == 0) begin : g_low
      assign xin = a_i;
      assign yin = b_i;
      assign zin = use_flag ? {{(W-1){1'b0}}, flag_q} : c_i;
    end else begin : g_up
      assign xin = a_hi_i;
      assign yin = b_hi_i;
      assign zin = {{(W-1){1'b0}}, g_lane[k-1].cnt[0]};
    end

    mwadd_adder3 #(.W(W)) u_add (
      .x  (xin),
      .y  (yin),
      .z  (zin),
      .sum(sum),
      .cnt(cnt)
    );
  end

  always_comb begin
    res_lo_d = '0;
    res_hi_d = '0;
    flag_we  = 1'b0;
    flag_d   = flag_q;
    case (op)
      OP_ADD:  res_lo_d = g_lane[0].sum;
      OP_GENC: res_lo_d = {{(W-2){1'b0}}, g_lane[0].cnt};
      OP_ADC: begin
        res_lo_d = g_lane[0].sum;
        flag_we  = valid_i;
        flag_d   = g_lane[0].cnt[0];
      end
      OP_CLRF: begin
        flag_we = valid_i;
        flag_d  = 1'b0;
      end
      OP_ADC2: begin
        res_lo_d = g_lane[0].sum;
        res_hi_d = g_lane[LANES-1].sum;
        flag_we  = valid_i;
        flag_d   = g_lane[LANES-1].cnt[0];
      end
      default: ;
    endcase
  end

  mwadd_flag u_flag (
    .clk(clk),
    .rst(rst),
    .we (flag_we),
    .d  (flag_d),
    .q  (flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      res_o    <= '0;
      res_hi_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o    <= res_lo_d;
        res_hi_o <= res_hi_d;
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mwadd_chk.sv
module mwadd_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] c_i,
  input logic         valid_o,
  input logic [W-1:0] res_o,
  input logic [W-1:0] res_hi_o,
  input logic         flag_o
);
  logic [W+1:0] tri_sum;
  logic [W:0]   fc_sum;

  assign tri_sum = {2'b00, a_i} + {2'b00, b_i} + {2'b00, c_i};
  assign fc_sum  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, flag_o};

  a_r1_add: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd0) |=> res_o == $past(tri_sum[W-1:0]));

  a_r2_flag_kept: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == 3'd0 || op_i == 3'd1)) |=> flag_o == $past(flag_o));

  a_r3_gen_carry: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd1) |=> res_o == {{(W-2){1'b0}}, $past(tri_sum[W+1:W])});

  a_r4_adc: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd2) |=> {flag_o, res_o} == $past(fc_sum));

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd3) |=> !flag_o && res_o == '0);

  a_r7_hi_zero: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i != 3'd4) |=> res_hi_o == '0);

  a_r8_valid: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o && $stable(res_o) && $stable(flag_o));

  a_r9_unused: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i > 3'd4) |=> res_o == '0 && flag_o == $past(flag_o));
endmodule

bind mwadd_unit mwadd_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .valid_i (valid_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .c_i     (c_i),
  .valid_o (valid_o),
  .res_o   (res_o),
  .res_hi_o(res_hi_o),
  .flag_o  (flag_o)
);

// File: tb/mwadd_unit_tb.sv
`timescale 1ns/1ps
module mwadd_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0, c_i = '0, a_hi_i = '0, b_hi_i = '0;
  logic        valid_o;
  logic [63:0] res_o, res_hi_o;
  logic        flag_o;

  int checks = 0;
  int fails  = 0;

  logic        s_vld, s_flag;
  logic [63:0] s_res, s_hi;

  always #4 clk = ~clk;

  mwadd_unit u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .a_hi_i(a_hi_i), .b_hi_i(b_hi_i),
    .valid_o(valid_o), .res_o(res_o), .res_hi_o(res_hi_o), .flag_o(flag_o)
  );

  localparam logic [63:0] ONES = '1;

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [65:0] ref3(input logic [63:0] a, b, c);
    return {2'b00, a} + {2'b00, b} + {2'b00, c};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sample();
    s_vld  = valid_o;
    s_res  = res_o;
    s_hi   = res_hi_o;
    s_flag = flag_o;
  endtask

  task automatic issue(input logic [2:0] op, input logic [63:0] a, b, c, ah, bh);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; c_i = c; a_hi_i = ah; b_hi_i = bh;
    @(posedge clk); #1;
    sample();
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0; op_i = 3'd0; a_i = rnd64(); b_i = rnd64(); c_i = rnd64();
    @(posedge clk); #1;
    sample();
  endtask

  // Sets the flag to 1 through an add with carry that overflows.
  task automatic set_flag();
    issue(3'd3, 0, 0, 0, 0, 0);
    issue(3'd2, ONES, 64'd1, 0, 0, 0);
  endtask

  task automatic chain_reg(input logic [255:0] a, b);
    logic [256:0] exp;
    logic [63:0]  cy;
    exp = {1'b0, a} + {1'b0, b};
    cy  = '0;
    for (int w = 0; w < 4; w++) begin
      issue(3'd0, a[w*64 +: 64], b[w*64 +: 64], cy, 0, 0);
      chk("R11 reg chain word", {64'd0, s_res}, {64'd0, exp[w*64 +: 64]});
      issue(3'd1, a[w*64 +: 64], b[w*64 +: 64], cy, 0, 0);
      cy = s_res;
    end
    chk("R11 reg chain bit256", {64'd0, cy}, {127'd0, exp[256]});
  endtask

  task automatic chain_flag(input logic [255:0] a, b);
    logic [256:0] exp;
    exp = {1'b0, a} + {1'b0, b};
    issue(3'd3, 0, 0, 0, 0, 0);
    for (int w = 0; w < 4; w++) begin
      issue(3'd2, a[w*64 +: 64], b[w*64 +: 64], rnd64(), 0, 0);
      chk("R11 flag chain word", {64'd0, s_res}, {64'd0, exp[w*64 +: 64]});
    end
    chk("R11 flag chain bit256", {127'd0, s_flag}, {127'd0, exp[256]});
  endtask

  task automatic chain_pair(input logic [255:0] a, b);
    logic [256:0] exp;
    exp = {1'b0, a} + {1'b0, b};
    issue(3'd3, 0, 0, 0, 0, 0);
    for (int p = 0; p < 2; p++) begin
      issue(3'd4, a[p*128 +: 64], b[p*128 +: 64], 0, a[p*128+64 +: 64], b[p*128+64 +: 64]);
      chk("R7 pair chain", {s_hi, s_res}, exp[p*128 +: 128]);
    end
    chk("R7 pair carry", {127'd0, s_flag}, {127'd0, exp[256]});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [255:0] ra, rb;
    logic [65:0]  e3;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1;
    sample();
    chk("R10 reset valid", {127'd0, s_vld}, 128'd0);
    chk("R10 reset result", {s_hi, s_res}, 128'd0);
    chk("R10 reset flag", {127'd0, s_flag}, 128'd0);
    @(negedge clk); rst = 1'b0;

    // R1 wrap around
    issue(3'd0, ONES, ONES, 64'd1, 0, 0);
    chk("R1 add wrap", {64'd0, s_res}, {64'd0, ONES});
    chk("R8 valid after strobe", {127'd0, s_vld}, 128'd1);
    chk("R7 hi zero for add", {64'd0, s_hi}, 128'd0);

    // R3 maximum carry count
    issue(3'd1, ONES, ONES, ONES, 0, 0);
    chk("R3 carry count two", {64'd0, s_res}, 128'd2);
    issue(3'd1, 64'd5, 64'd6, 64'd1, 0, 0);
    chk("R3 carry count zero", {64'd0, s_res}, 128'd0);

    // R2 flag kept by add and generate carry
    set_flag();
    chk("R4 adc carry out", {127'd0, s_flag}, 128'd1);
    chk("R4 adc sum", {64'd0, s_res}, 128'd0);
    issue(3'd0, 64'd1, 64'd2, 64'd3, 0, 0);
    chk("R2 flag after add", {127'd0, s_flag}, 128'd1);
    chk("R1 small add", {64'd0, s_res}, 128'd6);
    issue(3'd1, 0, 0, 0, 0, 0);
    chk("R2 flag after genc", {127'd0, s_flag}, 128'd1);

    // R9 unused opcodes
    for (int o = 5; o < 8; o++) begin
      issue(3'(o), ONES, ONES, ONES, ONES, ONES);
      chk("R9 unused result", {s_hi, s_res}, 128'd0);
      chk("R9 unused flag", {127'd0, s_flag}, 128'd1);
    end

    // R8 idle holds
    issue(3'd0, 64'd40, 64'd2, 0, 0, 0);
    idle();
    chk("R8 idle valid low", {127'd0, s_vld}, 128'd0);
    chk("R8 idle result held", {64'd0, s_res}, 128'd42);
    chk("R8 idle flag held", {127'd0, s_flag}, 128'd1);

    // R6 adc ignores c, uses flag=1
    issue(3'd2, 64'd10, 64'd20, ONES, 0, 0);
    chk("R6 adc ignores c", {64'd0, s_res}, 128'd31);
    chk("R4 adc no carry", {127'd0, s_flag}, 128'd0);

    // R5 clear
    set_flag();
    issue(3'd3, ONES, ONES, ONES, 0, 0);
    chk("R5 clear flag", {127'd0, s_flag}, 128'd0);
    chk("R5 clear result", {64'd0, s_res}, 128'd0);

    // Directed ripple through all words
    chain_reg({256{1'b1}}, 256'd1);
    chain_flag({256{1'b1}}, 256'd1);
    chain_pair({256{1'b1}}, 256'd1);

    for (int n = 0; n < 30; n++) begin
      ra = {rnd64(), rnd64(), rnd64(), rnd64()};
      rb = {rnd64(), rnd64(), rnd64(), rnd64()};
      chain_reg(ra, rb);
      chain_flag(ra, rb);
      chain_pair(ra, rb);
    end

    for (int n = 0; n < 40; n++) begin
      logic [63:0] x, y, z;
      x = rnd64(); y = rnd64(); z = rnd64();
      e3 = ref3(x, y, z);
      issue(3'd0, x, y, z, 0, 0);
      chk("R1 random add", {64'd0, s_res}, {64'd0, e3[63:0]});
      issue(3'd1, x, y, z, 0, 0);
      chk("R3 random carry", {64'd0, s_res}, {126'd0, e3[65:64]});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule